// File: doc/BRIEF.md
# Receive Byte Queue with Hysteresis Flow Thresholds

This block buffers received bytes between a serial deserializer and a host reader. Bytes enter through a push port and leave through a show-ahead read port. The queue reports whether it is empty or full and how many bytes it holds. It also drives two control outputs. A data-available interrupt is raised when the fill level reaches an upper threshold. A flow-stop flag tells the far end to pause, and it is released only after the level has fallen to a lower threshold.

The usable capacity and both thresholds depend on a 2-bit compatibility mode and a 2-bit trigger code. The modes are a single-byte holding mode, a 16-deep standard mode and two 128-deep extended modes. One extended mode uses widely separated upper and lower thresholds. The other extended mode always resumes at a level of one. A flush request empties the queue, but only in the queued modes. A move between single-byte mode and any queued mode empties the queue by itself.

Top module: `rx_hyst_fifo`

## Requirements
- R1: After reset the level is 0, `empty` is 1, and `irq`, `flow_stop` and `overrun` are 0.
- R2: Capacity is 1 in mode 00 (single byte), 16 in mode 01 (standard) and 128 in modes 10 and 11 (extended). `full` is 1 whenever the level is at or above the capacity of the current mode.
- R3: Bytes leave in arrival order. `rd_data` shows the oldest stored byte while the queue is not empty, and a pop advances to the next byte on the clock edge.
- R4: `level` counts the stored bytes. A push or a pop that is accepted changes it by one on the next edge. A push and a pop accepted in the same cycle leave it unchanged.
- R5: A pop while empty has no effect. The level stays 0 and no later byte is lost.
- R6: A push while `full` is dropped, and the level is not raised. `overrun` is 1 for exactly the cycle after such a push.
- R7: The upper threshold U depends on mode and trigger code 00/01/10/11. Mode 00 gives 1,1,1,1. Mode 01 gives 1,4,8,14. Mode 10 gives 16,32,112,120. Mode 11 gives 1,32,64,112. `irq` is 1 exactly while the level is at or above U.
- R8: The lower threshold L is 1 in modes 00 and 11. In mode 01 it equals U. In mode 10 it is 1,16,32,112 for codes 00 to 11. `flow_stop` is 1 whenever the level is at or above U. Once set, it stays 1 while the level is above L, and it falls in the same cycle that the level reaches L or below.
- R9: A `flush` in modes 01, 10 or 11 empties the queue on that edge and takes priority over a push or pop in the same cycle. In mode 00 `flush` has no effect.
- R10: A change of `mode` between 00 and any other value empties the queue on the first edge that sees the new mode. A change between two non-zero modes keeps the stored bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push | input | 1 | Write request from the deserializer |
| push_data | input | DW | Byte to store |
| pop | input | 1 | Host read strobe |
| flush | input | 1 | Request to empty the queue |
| mode | input | 2 | Compatibility mode selector |
| trig | input | 2 | Trigger code selector |
| rd_data | output | DW | Oldest stored byte (show-ahead) |
| empty | output | 1 | Queue holds no bytes |
| full | output | 1 | Level at mode capacity |
| level | output | LW | Number of stored bytes |
| irq | output | 1 | Data-available interrupt |
| flow_stop | output | 1 | Flow-control pause request with hysteresis |
| overrun | output | 1 | One-cycle pulse after a dropped push |

## Verification
The assertions assume that `mode` and `trig` change only while the queue is empty or between two non-zero modes. With that assumption, no threshold moves underneath a partly filled queue, except in the way R10 defines. They also assume that `push`, `pop` and `flush` are driven to known values at every edge after reset. The bench changes mode and trigger only when the queue has just been drained or deliberately emptied, apart from one directed move between two extended modes. It drives every control input on the falling edge, so each input is stable at the edge that samples it.

// File: rtl/rx_hyst_fifo.sv
module rx_hyst_fifo #(
  parameter int DW        = 8,
  parameter int DEPTH     = 128,
  parameter int STD_DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  input  logic          flush,
  input  logic [1:0]    mode,
  input  logic [1:0]    trig,
  output logic [DW-1:0] rd_data,
  output logic          empty,
  output logic          full,
  output logic [LW-1:0] level,
  output logic          irq,
  output logic          flow_stop,
  output logic          overrun
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [1:0]    mode_q;
  logic          flow_q;
  logic [LW-1:0] cap, hi, lo;

  always_comb begin
    unique case (mode)
      2'b00: begin cap = LW'(1); hi = LW'(1); lo = LW'(1); end
      2'b01: begin
        cap = LW'(STD_DEPTH);
        unique case (trig)
          2'b00: hi = LW'(1);
          2'b01: hi = LW'(4);
          2'b10: hi = LW'(8);
          default: hi = LW'(14);
        endcase
        lo = hi;
      end
      2'b10: begin
        cap = LW'(DEPTH);
        unique case (trig)
          2'b00: begin lo = LW'(1);   hi = LW'(16);  end
          2'b01: begin lo = LW'(16);  hi = LW'(32);  end
          2'b10: begin lo = LW'(32);  hi = LW'(112); end
          default: begin lo = LW'(112); hi = LW'(120); end
        endcase
      end
      default: begin
        cap = LW'(DEPTH);
        lo  = LW'(1);
        unique case (trig)
          2'b00: hi = LW'(1);
          2'b01: hi = LW'(32);
          2'b10: hi = LW'(64);
          default: hi = LW'(112);
        endcase
      end
    endcase
  end

  wire mode_chg = (mode == 2'b00) != (mode_q == 2'b00);
  wire clr      = mode_chg | (flush & (mode != 2'b00));
  assign empty  = (level == '0);
  assign full   = (level >= cap);
  wire do_push  = push & ~full;
  wire do_pop   = pop & ~empty;

  assign rd_data   = mem[rp];
  assign irq       = (level >= hi);
  assign flow_stop = (level >= hi) | (flow_q & (level > lo));

  always_ff @(posedge clk) begin
    if (do_push && !clr) mem[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp      <= '0;
      rp      <= '0;
      level   <= '0;
      mode_q  <= 2'b00;
      flow_q  <= 1'b0;
      overrun <= 1'b0;
    end else begin
      mode_q  <= mode;
      flow_q  <= flow_stop;
      overrun <= push & full;
      if (clr) begin
        wp    <= '0;
        rp    <= '0;
        level <= '0;
      end else begin
        if (do_push) wp <= wp + 1'b1;
        if (do_pop)  rp <= rp + 1'b1;
        case ({do_push, do_pop})
          2'b10:   level <= level + 1'b1;
          2'b01:   level <= level - 1'b1;
          default: level <= level;
        endcase
      end
    end
  end

endmodule

module rx_hyst_fifo_chk #(
  parameter int DEPTH = 128,
  parameter int LW    = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          push,
  input logic          pop,
  input logic          flush,
  input logic [1:0]    mode,
  input logic          empty,
  input logic          full,
  input logic [LW-1:0] level,
  input logic          irq,
  input logic          flow_stop,
  input logic          overrun
);

  assert_level_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));

  assert_no_raise_when_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> (level <= $past(level)));

  assert_overrun_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full) |=> overrun);

  assert_empty_pop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push) |=> empty);

  assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && mode != 2'b00) |=> empty);

  assert_irq_implies_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flow_stop);

  assert_stop_rise_with_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flow_stop) |-> irq);

endmodule

bind rx_hyst_fifo rx_hyst_fifo_chk #(.DEPTH(DEPTH), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .flush(flush), .mode(mode),
  .empty(empty), .full(full), .level(level), .irq(irq), .flow_stop(flow_stop),
  .overrun(overrun)
);

// File: tb/rx_hyst_fifo_bench.sv
module rx_hyst_fifo_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LW = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       push = 1'b0, pop = 1'b0, flush = 1'b0;
  logic [7:0] push_data = '0;
  logic [1:0] mode = 2'b00, trig = 2'b00;
  logic [7:0] rd_data;
  logic       empty, full, irq, flow_stop, overrun;
  logic [LW-1:0] level;

  int tests = 0, fails = 0;
  int md = 0, tg = 0, pmode = 0;
  bit fexp = 0;
  logic [7:0] q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_hyst_fifo u_rx_hyst_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data), .pop(pop),
    .flush(flush), .mode(mode), .trig(trig), .rd_data(rd_data), .empty(empty),
    .full(full), .level(level), .irq(irq), .flow_stop(flow_stop), .overrun(overrun)
  );

  function automatic int cap_of(int m);
    return (m == 0) ? 1 : (m == 1) ? 16 : 128;
  endfunction

  function automatic int hi_of(int m, int t);
    case (m)
      0: return 1;
      1: return (t == 0) ? 1 : (t == 1) ? 4 : (t == 2) ? 8 : 14;
      2: return (t == 0) ? 16 : (t == 1) ? 32 : (t == 2) ? 112 : 120;
      default: return (t == 0) ? 1 : t * 32 + ((t == 3) ? 16 : 0);
    endcase
  endfunction

  function automatic int lo_of(int m, int t);
    case (m)
      1: return hi_of(m, t);
      2: return (t == 0) ? 1 : (t == 1) ? 16 : (t == 2) ? 32 : 112;
      default: return 1;
    endcase
  endfunction

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (mode %0d trig %0d)", req, act, exp, md, tg);
    end
  endtask

  task automatic step(bit p, bit pp, bit f, logic [7:0] d);
    int capv, lv;
    bit fullm, ovx, clr;
    @(negedge clk);
    push = p; pop = pp; flush = f; push_data = d;
    mode = md[1:0]; trig = tg[1:0];
    capv  = cap_of(md);
    fullm = q.size() >= capv;
    ovx   = p && fullm;
    clr   = ((md == 0) != (pmode == 0)) || (f && md != 0);
    if (clr) q.delete();
    else begin
      bit dq;
      dq = pp && q.size() > 0;
      if (dq) void'(q.pop_front());
      if (p && !fullm) q.push_back(d);
    end
    pmode = md;
    lv = q.size();
    fexp = (lv >= hi_of(md, tg)) || (fexp && lv > lo_of(md, tg));
    @(posedge clk); #1;
    check("R4 level", int'(level), lv);
    check("R2 full", int'(full), int'(lv >= capv));
    check("R7 irq", int'(irq), int'(lv >= hi_of(md, tg)));
    check("R8 flow_stop", int'(flow_stop), int'(fexp));
    check("R6 overrun", int'(overrun), int'(ovx));
    check("R5 empty", int'(empty), int'(lv == 0));
    if (lv > 0) check("R3 rd_data", int'(rd_data), int'(q[0]));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 level", int'(level), 0);
    check("R1 empty", int'(empty), 1);
    check("R1 irq", int'(irq), 0);
    check("R1 flow_stop", int'(flow_stop), 0);
    check("R1 overrun", int'(overrun), 0);
    @(negedge clk); rst_n = 1'b1;

    // sweep all modes and trigger codes: fill past capacity, then drain past empty
    for (int m = 0; m < 4; m++) begin
      for (int t = 0; t < 4; t++) begin
        md = m; tg = t;
        step(0, 0, 0, 8'h00);
        for (int i = 0; i <= cap_of(m); i++) step(1, 0, 0, 8'((m * 53) + (t * 17) + i * 3));
        for (int i = 0; i <= cap_of(m); i++) step(0, 1, 0, 8'h00);
      end
    end

    // R4 simultaneous push and pop keeps the level
    md = 2; tg = 1;
    step(0, 0, 0, 8'h00);
    for (int i = 0; i < 20; i++) step(1, 0, 0, 8'(i + 100));
    for (int i = 0; i < 10; i++) step(1, 1, 0, 8'(i + 200));
    check("R4 level after push+pop", int'(level), 20);

    // R9 flush in extended mode, with push in the same cycle
    step(1, 0, 1, 8'hAA);
    check("R9 flush empties", int'(level), 0);

    // R5 pop while empty, then a byte survives
    step(0, 1, 0, 8'h00);
    step(1, 0, 0, 8'h5C);
    check("R5 byte after empty pop", int'(rd_data), 8'h5C);
    step(0, 1, 0, 8'h00);

    // R9 flush ignored in single-byte mode
    md = 0; tg = 0;
    step(0, 0, 0, 8'h00);
    step(1, 0, 0, 8'h3E);
    step(0, 0, 1, 8'h00);
    check("R9 flush ignored in mode 00", int'(level), 1);
    check("R9 byte kept in mode 00", int'(rd_data), 8'h3E);

    // R10 single-byte to queued mode flushes
    md = 1; tg = 0;
    step(0, 0, 0, 8'h00);
    check("R10 mode 00->01 flushes", int'(level), 0);

    // R10 queued to queued keeps contents
    for (int i = 0; i < 3; i++) step(1, 0, 0, 8'(i + 7));
    md = 2;
    step(0, 0, 0, 8'h00);
    check("R10 mode 01->10 keeps level", int'(level), 3);
    check("R10 mode 01->10 keeps data", int'(rd_data), 7);
    md = 0;
    step(0, 0, 0, 8'h00);
    check("R10 mode 10->00 flushes", int'(level), 0);
    step(0, 0, 0, 8'h00);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule